// File: doc/BRIEF.md
# Two-Register Bidirectional Shift Unit

This block holds an N-bit working value and moves it by exactly one bit position, left or right, on command. The shift is never done in place. A separate holding register and a short phase sequencer carry it out as four clocked parallel transfers. First the working value is copied into the holding register. Then the working register is cleared. Then the holding contents are written back, offset by one bit. Finally the holding register is cleared, ready for the next command.

A client writes a value through the parallel-load port while the unit is idle. It then pulses `start` with a direction and two fill bits. It sees `busy` for four clocks and then a one-clock `done` pulse, after which `data_q` carries the shifted value. The holding register is visible on `hold_q`, so its cleared state between operations can be observed.

Top module: `bidir_shift_unit`

## Requirements
- R1: While `rst_n` is low, `data_q` and `hold_q` read all zeros, `busy` and `done` are 0, and the sequencer is idle.
- R2: When `load_en` is high on a clock edge while idle, `data_q` equals `load_data` after that edge, and `hold_q` stays zero.
- R3: `load_en` has no effect while `busy` is high; the shift result is unchanged by it.
- R4: `start` is ignored while `busy` is high; one accepted command produces exactly one single-bit shift.
- R5: One clock after `start` is accepted, `hold_q` equals the working value that was present at acceptance, and `data_q` is unchanged.
- R6: Two clocks after acceptance, `data_q` is all zeros.
- R7: Three clocks after acceptance, `data_q` holds the shifted value. With `dir_left`=1: `{hold[N-2:0], fill_left}`. With `dir_left`=0: `{fill_right, hold[N-1:1]}`. The direction and the fill bit are taken on the accepting clock, and later changes to them are ignored.
- R8: The holding register is zero whenever the unit is idle, including right before a copy phase and one clock after the write-back.
- R9: `busy` is high for exactly four clocks after the accepting edge. `done` is then high for exactly one clock, with `busy` low.
- R10: When `load_en` and `start` are both high on the same idle clock edge, the load is applied and the shift then operates on the newly loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| load_en | input | 1 | Parallel-write strobe for the working register, honoured only while idle |
| load_data | input | N | Value to write into the working register |
| start | input | 1 | Begins one single-bit shift when idle |
| dir_left | input | 1 | 1 selects a shift toward the MSB, 0 a shift toward the LSB |
| fill_left | input | 1 | Bit entering at the LSB on a left shift |
| fill_right | input | 1 | Bit entering at the MSB on a right shift |
| data_q | output | N | Working register contents |
| hold_q | output | N | Holding register contents |
| busy | output | 1 | High while a shift sequence is in progress |
| done | output | 1 | One-clock pulse after the final phase |

## Verification
Two functions can meet on one clock edge: a parallel load and the acceptance of a shift command. The bench drives `load_en` and `start` high together while the unit is idle. It then judges the final `data_q` against a one-bit shift of the loaded value, not of the old contents. A second collision, a load or a start arriving while a sequence is running, is provoked by holding both strobes high through the busy window. It is judged by requiring the exact single-shift result and a single `done` pulse.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_COPY = 3'd1,
    PH_CLRW = 3'd2,
    PH_BACK = 3'd3,
    PH_CLRH = 3'd4
  } phase_e;
endpackage

// File: rtl/shift_phase_seq.sv
module shift_phase_seq
  import shift_unit_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   dir_left,
  input  logic   fill_left,
  input  logic   fill_right,
  output phase_e phase,
  output logic   cmd_left,
  output logic   cmd_fill,
  output logic   busy,
  output logic   done
);
  phase_e phase_q, phase_d;
  logic   left_q, fill_q, done_q;
  logic   cap_en;

  assign cap_en = (phase_q == PH_IDLE) && start;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (start) phase_d = PH_COPY;
      PH_COPY: phase_d = PH_CLRW;
      PH_CLRW: phase_d = PH_BACK;
      PH_BACK: phase_d = PH_CLRH;
      PH_CLRH: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      left_q  <= 1'b0;
      fill_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == PH_CLRH);
      if (cap_en) begin
        left_q <= dir_left;
        fill_q <= dir_left ? fill_left : fill_right;
      end
    end
  end

  assign phase    = phase_q;
  assign cmd_left = left_q;
  assign cmd_fill = fill_q;
  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;

  // R9: phases step in strict order, one per clock
  assert_phase_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COPY) |=> (phase_q == PH_CLRW));
  assert_phase_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CLRW) |=> (phase_q == PH_BACK));
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CLRH) |=> (done && !busy));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: a start during a running sequence never re-enters the copy phase
  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase_q != PH_CLRH) |=> (phase_q != PH_COPY));
  // R7: the captured command is stable for the whole sequence
  assert_cmd_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase_q != PH_IDLE) |=> ($stable(left_q) && $stable(fill_q)));
endmodule

// File: rtl/shift_hold_reg.sv
module shift_hold_reg
  import shift_unit_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic [WIDTH-1:0] work_in,
  output logic [WIDTH-1:0] hold_q
);
  logic [WIDTH-1:0] hold_r, hold_d;
  logic             hold_en;

  always_comb begin
    hold_en = 1'b0;
    hold_d  = hold_r;
    case (phase)
      PH_COPY: begin hold_en = 1'b1; hold_d = work_in;        end
      PH_CLRH: begin hold_en = 1'b1; hold_d = '0;             end
      default: begin hold_en = 1'b0; hold_d = hold_r;         end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_r <= '0;
    else if (hold_en) hold_r <= hold_d;
  end

  assign hold_q = hold_r;

  // R8: cleared before the copy phase and while idle
  assert_hold_clear_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COPY) |-> (hold_r == '0));
  assert_hold_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (hold_r == '0));
  // R5: copy phase captures the working register
  assert_copy_captures_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COPY) |=> (hold_r == $past(work_in)));
endmodule

// File: rtl/shift_work_reg.sv
module shift_work_reg
  import shift_unit_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  input  logic [WIDTH-1:0] hold_in,
  input  logic             cmd_left,
  input  logic             cmd_fill,
  output logic [WIDTH-1:0] work_q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] work_r, work_d, offset_val;
  logic             work_en;

  for (genvar i = 0; i < WIDTH; i++) begin : g_offset
    logic from_lower, from_upper;
    if (i == 0) begin : g_lsb
      assign from_lower = cmd_fill;
    end else begin : g_lsb_n
      assign from_lower = hold_in[i-1];
    end
    if (i == MSB) begin : g_msb
      assign from_upper = cmd_fill;
    end else begin : g_msb_n
      assign from_upper = hold_in[i+1];
    end
    assign offset_val[i] = cmd_left ? from_lower : from_upper;
  end

  always_comb begin
    work_en = 1'b0;
    work_d  = work_r;
    case (phase)
      PH_IDLE: begin work_en = load_en; work_d = load_data;  end
      PH_CLRW: begin work_en = 1'b1;    work_d = '0;         end
      PH_BACK: begin work_en = 1'b1;    work_d = offset_val; end
      default: begin work_en = 1'b0;    work_d = work_r;     end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       work_r <= '0;
    else if (work_en) work_r <= work_d;
  end

  assign work_q = work_r;

  // R6: clear phase empties the working register
  assert_work_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLRW) |=> (work_r == '0));
  // R3: loads are ignored during copy and final clear phases
  assert_load_ignored_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COPY) |=> $stable(work_r));
  assert_load_ignored_clrh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLRH) |=> $stable(work_r));
  // R7: the bit shifted out never survives in the entry position
  assert_left_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BACK && cmd_left) |=> (work_r[0] == $past(cmd_fill)));
  assert_right_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BACK && !cmd_left) |=> (work_r[MSB] == $past(cmd_fill)));
endmodule

// File: rtl/bidir_shift_unit.sv
module bidir_shift_unit
  import shift_unit_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  input  logic             start,
  input  logic             dir_left,
  input  logic             fill_left,
  input  logic             fill_right,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] hold_q,
  output logic             busy,
  output logic             done
);
  phase_e           phase;
  logic             cmd_left, cmd_fill;
  logic [WIDTH-1:0] work_w, hold_w;

  shift_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dir_left   (dir_left),
    .fill_left  (fill_left),
    .fill_right (fill_right),
    .phase      (phase),
    .cmd_left   (cmd_left),
    .cmd_fill   (cmd_fill),
    .busy       (busy),
    .done       (done)
  );

  shift_work_reg #(.WIDTH(WIDTH)) u_work (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .load_en   (load_en),
    .load_data (load_data),
    .hold_in   (hold_w),
    .cmd_left  (cmd_left),
    .cmd_fill  (cmd_fill),
    .work_q    (work_w)
  );

  shift_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .work_in (work_w),
    .hold_q  (hold_w)
  );

  assign data_q = work_w;
  assign hold_q = hold_w;

  // R10: an idle start is always followed by busy on the next cycle
  assert_start_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  // R2: an idle load without start writes the working register
  assert_idle_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load_en) |=> (data_q == $past(load_data)));
endmodule

// File: tb/bidir_shift_unit_tb.sv
`timescale 1ns/1ps
module bidir_shift_unit_tb_top;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_en, start, dir_left, fill_left, fill_right;
  logic [W-1:0] load_data;
  logic [W-1:0] data_q, hold_q;
  logic         busy, done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  bidir_shift_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
    .start(start), .dir_left(dir_left), .fill_left(fill_left),
    .fill_right(fill_right), .data_q(data_q), .hold_q(hold_q),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int shifted(input int v, input bit left, input bit fl, input bit fr);
    if (left) return ((v << 1) | int'(fl)) & MASK;
    return (v >> 1) | (int'(fr) << (W - 1));
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input int v);
    load_en = 1'b1; load_data = W'(v);
    step();
    load_en = 1'b0;
    chk("R2 load data", int'(data_q), v);
    chk("R2 hold zero", int'(hold_q), 0);
  endtask

  // full four-phase check; noise=1 keeps start/load high during busy
  task automatic do_shift(input int v, input bit left, input bit fl, input bit fr,
                          input bit noise);
    int exp;
    exp = shifted(v, left, fl, fr);
    start = 1'b1; dir_left = left; fill_left = fl; fill_right = fr;
    step();
    start = noise; load_en = noise; load_data = W'(~v);
    dir_left = ~left; fill_left = ~fl; fill_right = ~fr;
    chk("R9 busy after accept", int'(busy), 1);
    chk("R8 hold zero before copy", int'(hold_q), 0);
    step();
    chk("R5 hold copy", int'(hold_q), v);
    chk("R5 data unchanged", int'(data_q), v);
    step();
    chk("R6 data cleared", int'(data_q), 0);
    step();
    chk("R7 shifted value", int'(data_q), exp);
    chk("R9 busy phase3", int'(busy), 1);
    start = 1'b0; load_en = 1'b0;
    step();
    chk("R9 busy low", int'(busy), 0);
    chk("R9 done pulse", int'(done), 1);
    chk("R8 hold cleared", int'(hold_q), 0);
    chk(noise ? "R3 R4 result under noise" : "R7 final value", int'(data_q), exp);
    step();
    chk("R9 done single", int'(done), 0);
    chk("R4 no restart", int'(busy), 0);
    chk("R8 hold idle", int'(hold_q), 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_en = 1'b0; start = 1'b0; dir_left = 1'b0;
    fill_left = 1'b0; fill_right = 1'b0; load_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 data reset", int'(data_q), 0);
    chk("R1 hold reset", int'(hold_q), 0);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 done reset", int'(done), 0);
    rst_n = 1'b1;
    step();

    for (int v = 0; v <= MASK; v++) begin
      for (int d = 0; d < 2; d++) begin
        for (int f = 0; f < 4; f++) begin
          do_load(v);
          do_shift(v, d[0], f[0], f[1], 1'b0);
        end
      end
    end

    // R3 and R4: strobes held high through the busy window
    do_load(4'h9);
    do_shift(4'h9, 1'b1, 1'b1, 1'b0, 1'b1);
    do_load(4'h6);
    do_shift(4'h6, 1'b0, 1'b0, 1'b1, 1'b1);

    // R10: load and start on the same idle edge
    do_load(4'h0);
    for (int v = 1; v <= MASK; v += 5) begin
      load_en = 1'b1; load_data = W'(v);
      do_shift(v, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R10 shift of loaded value", int'(data_q), shifted(v, 1'b1, 1'b0, 1'b0));
    end

    // R1: reset in the middle of a sequence
    do_load(4'hF);
    start = 1'b1; dir_left = 1'b1;
    step();
    start = 1'b0;
    step();
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run data", int'(data_q), 0);
    chk("R1 mid-run hold", int'(hold_q), 0);
    chk("R1 mid-run busy", int'(busy), 0);
    step();
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", int'(busy), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule